// File: doc/BRIEF.md
# Six-Channel Metering ADC Frame Deserializer

This block sits behind a three-phase metering converter that streams each conversion result as one serial frame. The converter drives a frame-sync line, a burst-gated serial clock and a data line. All three are asynchronous to the system clock, so the block brings them into its clock domain and finds the frame boundary and the serial clock edges there. It gathers the 96 data bits of a frame and splits them into six signed 16-bit samples, a voltage and a current for each phase. It then delivers all six together with a single-cycle strobe.

A frame begins when frame sync falls. The serial clock runs only while frame sync is low and idles low between frames. Data bits are taken on serial clock rising edges, most significant bit first. If a frame ends early, or if the serial clock runs past its 96th edge, the frame is flagged through a sticky error output. The flag stays set until the system side clears it. Bits and clock edges seen while frame sync is high play no part in the result.

Top module: `frame_deser`

## Requirements
- R1: When reset is released, `sample_bus` is zero and both `sample_valid` and `frame_err` are low.
- R2: While frame sync is high, serial clock edges and data are ignored. `sample_valid` stays low, `sample_bus` keeps its value and `frame_err` does not change.
- R3: Each frame is 96 bits sent MSB first, and each bit is taken at a serial clock rising edge. The first bit after frame sync falls is bit 15 of word 0. Word k sits at `sample_bus[16k+15:16k]` as a two's complement value, with k=0 phase 1 voltage, k=1 phase 1 current, k=2 phase 2 voltage, k=3 phase 2 current, k=4 phase 3 voltage and k=5 phase 3 current.
- R4: On the 96th rising edge all six words update in the same cycle, and `sample_valid` is high for exactly that one cycle. In every other cycle `sample_bus` holds its value.
- R5: If frame sync rises before 96 edges have arrived, the frame is dropped. No valid strobe is given, `sample_bus` is unchanged and `frame_err` is set.
- R6: A serial clock rising edge after the 96th edge and before frame sync rises sets `frame_err`. The words already delivered stay on `sample_bus`.
- R7: `frame_err` stays set until `err_clr` is high at a clock edge, and it reads low from the following cycle. If an error is detected in the same cycle that `err_clr` is high, the flag ends up set.
- R8: The bit counter restarts on every falling edge of frame sync, so a full frame after a dropped frame is received correctly.
- R9: Reset is synchronous and active low. Any low pulse of at least 50 ns (two or more 50 MHz edges) restores the R1 state from any point in a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync_in | input | 1 | Frame sync from converter; falling edge starts a frame |
| sclk_in | input | 1 | Gated serial clock from converter |
| sdata_in | input | 1 | Serial data, valid at serial clock rising edge |
| err_clr | input | 1 | Clears the sticky frame error flag |
| sample_bus | output | 96 | Six signed 16-bit samples, word k at bits 16k+15:16k |
| sample_valid | output | 1 | One-cycle strobe when a new set of samples is present |
| frame_err | output | 1 | Sticky flag for short or overlong frames |

## Verification
The error flag can be set and cleared in the same cycle. This happens when a frame-sync rise that cuts a frame short is detected in the same cycle that `err_clr` is high. The bench first clears the flag, then sends a 20-bit frame and raises frame sync. It places the `err_clr` pulse two system clocks later, which is when the synchronized rise reaches the error logic. The flag must read high afterwards. Separate checks confirm that the flag holds with no clear and drops after a clear with no error pending.

// File: rtl/frame_deser_pkg.sv
package frame_deser_pkg;

  // Receive state of the frame tracker
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // waiting for frame sync to fall
    ST_RECV = 2'd1,  // collecting frame bits
    ST_TAIL = 2'd2   // full frame taken, waiting for frame sync to rise
  } frame_st_t;

  localparam int DEF_WORD_W  = 16;
  localparam int DEF_N_WORDS = 6;
  localparam int DEF_SYNC    = 2;

endpackage

// File: rtl/frame_deser_sync.sv
module frame_deser_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/frame_deser_framer.sv
module frame_deser_framer
  import frame_deser_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int N_WORDS = 6,
  localparam int FRAME_BITS = WORD_W * N_WORDS,
  localparam int CNT_W      = $clog2(FRAME_BITS + 1),
  localparam int BIT_W      = $clog2(WORD_W),
  localparam int IDX_W      = CNT_W - BIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_fall,
  input  logic              fs_rise,
  input  logic              sck_rise,
  input  logic              sd,
  input  logic              err_clr,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [WORD_W-1:0] wr_data,
  output logic              frame_done,
  output logic              err_set,
  output logic              frame_err
);

  frame_st_t         st;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] sh_next;
  logic              word_end;
  logic              frame_end;

  assign sh_next   = {shreg[WORD_W-2:0], sd};
  assign word_end  = (cnt[BIT_W-1:0] == BIT_W'(WORD_W - 1));
  assign frame_end = (cnt == CNT_W'(FRAME_BITS - 1));

  // Early end of frame, or a clock edge past the last bit
  assign err_set = ((st == ST_RECV) && fs_rise) ||
                   ((st == ST_TAIL) && sck_rise && !fs_rise);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      shreg      <= '0;
      wr_en      <= 1'b0;
      wr_idx     <= '0;
      wr_data    <= '0;
      frame_done <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      wr_en      <= 1'b0;
      frame_done <= 1'b0;

      if (err_set)      frame_err <= 1'b1;
      else if (err_clr) frame_err <= 1'b0;

      if (fs_fall) begin
        st  <= ST_RECV;
        cnt <= '0;
      end else begin
        case (st)
          ST_RECV: begin
            if (fs_rise) begin
              st <= ST_IDLE;
            end else if (sck_rise) begin
              shreg <= sh_next;
              cnt   <= cnt + 1'b1;
              if (word_end) begin
                wr_en   <= 1'b1;
                wr_idx  <= cnt[CNT_W-1:BIT_W];
                wr_data <= sh_next;
              end
              if (frame_end) begin
                frame_done <= 1'b1;
                st         <= ST_TAIL;
              end
            end
          end
          ST_TAIL: begin
            if (fs_rise) st <= ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/frame_deser_outregs.sv
module frame_deser_outregs #(
  parameter int WORD_W  = 16,
  parameter int N_WORDS = 6,
  parameter int IDX_W   = 3,
  localparam int BUS_W  = WORD_W * N_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              frame_done,
  output logic [BUS_W-1:0]  sample_bus,
  output logic              sample_valid
);

  // Staging words for the frame in progress; no reset needed
  logic [WORD_W-1:0] stage_mem [N_WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) stage_mem[wr_idx] <= wr_data;
  end

  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    logic [WORD_W-1:0] out_q;
    if (k == N_WORDS - 1) begin : g_last
      // Final word arrives with the done pulse and bypasses staging
      always_ff @(posedge clk) begin
        if (!rst_n)          out_q <= '0;
        else if (frame_done) out_q <= wr_data;
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (!rst_n)          out_q <= '0;
        else if (frame_done) out_q <= stage_mem[k];
      end
    end
    assign sample_bus[k*WORD_W +: WORD_W] = out_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sample_valid <= 1'b0;
    else        sample_valid <= frame_done;
  end

endmodule

// File: rtl/frame_deser.sv
module frame_deser
  import frame_deser_pkg::*;
#(
  parameter int WORD_W      = DEF_WORD_W,
  parameter int N_WORDS     = DEF_N_WORDS,
  parameter int SYNC_STAGES = DEF_SYNC,
  localparam int BUS_W      = WORD_W * N_WORDS,
  localparam int CNT_W      = $clog2(BUS_W + 1),
  localparam int IDX_W      = CNT_W - $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync_in,
  input  logic             sclk_in,
  input  logic             sdata_in,
  input  logic             err_clr,
  output logic [BUS_W-1:0] sample_bus,
  output logic             sample_valid,
  output logic             frame_err
);

  logic [2:0]        sync_q;   // {data, sclk, fsync}
  logic [1:0]        edge_q;   // {sclk, fsync} one cycle later
  logic              fs_fall, fs_rise, sck_rise;
  logic              wr_en, frame_done, err_set;
  logic [IDX_W-1:0]  wr_idx;
  logic [WORD_W-1:0] wr_data;

  frame_deser_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({sdata_in, sclk_in, fsync_in}),
    .dout (sync_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) edge_q <= '0;
    else        edge_q <= sync_q[1:0];
  end

  assign fs_fall  = !sync_q[0] &&  edge_q[0];
  assign fs_rise  =  sync_q[0] && !edge_q[0];
  assign sck_rise =  sync_q[1] && !edge_q[1];

  frame_deser_framer #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .fs_fall   (fs_fall),
    .fs_rise   (fs_rise),
    .sck_rise  (sck_rise),
    .sd        (sync_q[2]),
    .err_clr   (err_clr),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .frame_done(frame_done),
    .err_set   (err_set),
    .frame_err (frame_err)
  );

  frame_deser_outregs #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .IDX_W(IDX_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .frame_done  (frame_done),
    .sample_bus  (sample_bus),
    .sample_valid(sample_valid)
  );

endmodule

// File: rtl/frame_deser_chk.sv
module frame_deser_chk #(
  parameter int BUS_W = 96
) (
  input logic             clk,
  input logic             rst_n,
  input logic             err_clr,
  input logic             err_set,
  input logic [BUS_W-1:0] sample_bus,
  input logic             sample_valid,
  input logic             frame_err
);

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (sample_bus == '0 && !sample_valid && !frame_err));

  assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  assert_bus_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |-> $stable(sample_bus));

  // R5 and R6: the flag rises only after a detected framing fault
  assert_err_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> $past(err_set));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && !err_clr) |=> frame_err);

  assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !err_set) |=> !frame_err);

  assert_err_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> frame_err);

endmodule

bind frame_deser frame_deser_chk #(.BUS_W(WORD_W * N_WORDS)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .err_clr     (err_clr),
  .err_set     (err_set),
  .sample_bus  (sample_bus),
  .sample_valid(sample_valid),
  .frame_err   (frame_err)
);

// File: tb/frame_deser_tb_top.sv
`timescale 1ns/1ps
module frame_deser_tb_top;

  localparam int WORD_W  = 16;
  localparam int N_WORDS = 6;
  localparam int BUS_W   = WORD_W * N_WORDS;

  logic             clk = 1'b0;
  logic             rst_n, fsync_in, sclk_in, sdata_in, err_clr;
  logic [BUS_W-1:0] sample_bus;
  logic             sample_valid, frame_err;

  int checks = 0;
  int failures = 0;
  int valid_cnt = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [BUS_W-1:0] cap_bus = '0;

  always #10 clk = ~clk;  // 50 MHz

  frame_deser dut_i (
    .clk(clk), .rst_n(rst_n), .fsync_in(fsync_in), .sclk_in(sclk_in),
    .sdata_in(sdata_in), .err_clr(err_clr), .sample_bus(sample_bus),
    .sample_valid(sample_valid), .frame_err(frame_err)
  );

  always @(negedge clk) begin
    if (sample_valid) begin
      valid_cnt++;
      cap_bus = sample_bus;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      failures++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Serial position i carries this bit of the sample bus (R3 ordering)
  function automatic logic bit_of(input logic [BUS_W-1:0] bus, input int i);
    return bus[(i / WORD_W) * WORD_W + (WORD_W - 1 - (i % WORD_W))];
  endfunction

  function automatic logic [WORD_W-1:0] word_of(input logic [BUS_W-1:0] bus, input int k);
    return bus[k*WORD_W +: WORD_W];
  endfunction

  task automatic check(input string req, input string what,
                       input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send_frame(input logic [BUS_W-1:0] bus, input int nbits, input bit raise_fs);
    @(negedge clk) fsync_in = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      int lo;
      int hi;
      lo = 2 + int'($urandom_range(2));
      hi = 2 + int'($urandom_range(2));
      sclk_in  = 1'b0;
      sdata_in = (i < BUS_W) ? bit_of(bus, i) : 1'($urandom_range(1));
      repeat (lo) @(negedge clk);
      sclk_in = 1'b1;
      @(negedge clk);
      sdata_in = 1'($urandom_range(1));  // change after the edge: must not matter
      repeat (hi - 1) @(negedge clk);
    end
    sclk_in  = 1'b0;
    sdata_in = 1'($urandom_range(1));
    repeat (3) @(negedge clk);
    if (raise_fs) begin
      fsync_in = 1'b1;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic pulse_clr;
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
  endtask

  function automatic logic [BUS_W-1:0] rand_bus();
    return {$urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [BUS_W-1:0] exp_bus;
    logic [BUS_W-1:0] prev_bus;
    int               vc;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; fsync_in = 1'b1; sclk_in = 1'b0; sdata_in = 1'b0; err_clr = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "bus after reset", sample_bus, '0);
    check("R1", "valid after reset", BUS_W'(sample_valid), '0);
    check("R1", "err after reset", BUS_W'(frame_err), '0);

    // R2: clock edges and data with frame sync high
    for (int i = 0; i < 40; i++) begin
      @(negedge clk) sclk_in = 1'b0; sdata_in = 1'($urandom_range(1));
      repeat (2) @(negedge clk);
      sclk_in = 1'b1;
      repeat (2) @(negedge clk);
    end
    sclk_in = 1'b0;
    repeat (6) @(negedge clk);
    check("R2", "valid count idle edges", BUS_W'(valid_cnt), '0);
    check("R2", "bus idle edges", sample_bus, '0);
    check("R2", "err idle edges", BUS_W'(frame_err), '0);

    // R3: directed frame with distinct signed words per channel
    exp_bus = {16'hFFFF, 16'h0001, 16'hC3A5, 16'h5A3C, 16'h7FFE, 16'h8001};
    send_frame(exp_bus, BUS_W, 1'b1);
    check("R3", "valid count directed", BUS_W'(valid_cnt), BUS_W'(1));
    check("R3", "phase1 voltage", BUS_W'(word_of(cap_bus, 0)), BUS_W'(16'h8001));
    check("R3", "phase1 current", BUS_W'(word_of(cap_bus, 1)), BUS_W'(16'h7FFE));
    check("R3", "phase2 voltage", BUS_W'(word_of(cap_bus, 2)), BUS_W'(16'h5A3C));
    check("R3", "phase2 current", BUS_W'(word_of(cap_bus, 3)), BUS_W'(16'hC3A5));
    check("R3", "phase3 voltage", BUS_W'(word_of(cap_bus, 4)), BUS_W'(16'h0001));
    check("R3", "phase3 current", BUS_W'(word_of(cap_bus, 5)), BUS_W'(16'hFFFF));
    checks++;
    if ($signed(word_of(sample_bus, 0)) != -32767) begin
      failures++;
      $display("FAIL R3 signed phase1 voltage actual=%0d expected=-32767",
               $signed(word_of(sample_bus, 0)));
    end

    // R4: random frames, all six words and one strobe each
    for (int f = 0; f < 20; f++) begin
      vc = valid_cnt;
      exp_bus = rand_bus();
      send_frame(exp_bus, BUS_W, 1'b1);
      check("R4", "random frame bus", sample_bus, exp_bus);
      check("R4", "random frame strobe count", BUS_W'(valid_cnt - vc), BUS_W'(1));
      check("R4", "random frame err", BUS_W'(frame_err), '0);
    end

    // R5: short frame dropped
    prev_bus = sample_bus;
    vc = valid_cnt;
    send_frame(rand_bus(), 50, 1'b1);
    check("R5", "short frame strobe count", BUS_W'(valid_cnt - vc), '0);
    check("R5", "short frame bus unchanged", sample_bus, prev_bus);
    check("R5", "short frame err", BUS_W'(frame_err), BUS_W'(1));
    pulse_clr();
    @(negedge clk);
    check("R7", "err after clear", BUS_W'(frame_err), '0);

    // R8: full frame right after a dropped one
    exp_bus = rand_bus();
    send_frame(exp_bus, BUS_W, 1'b1);
    check("R8", "frame after abort bus", sample_bus, exp_bus);
    check("R8", "frame after abort err", BUS_W'(frame_err), '0);

    // R6: one edge too many
    vc = valid_cnt;
    exp_bus = rand_bus();
    send_frame(exp_bus, BUS_W + 1, 1'b1);
    check("R6", "overrun strobe count", BUS_W'(valid_cnt - vc), BUS_W'(1));
    check("R6", "overrun bus kept", sample_bus, exp_bus);
    check("R6", "overrun err", BUS_W'(frame_err), BUS_W'(1));
    pulse_clr();
    @(negedge clk);
    check("R7", "err cleared after overrun", BUS_W'(frame_err), '0);

    // R7: error detection and clear in the same cycle
    send_frame(rand_bus(), 20, 1'b0);
    @(negedge clk) fsync_in = 1'b1;
    @(negedge clk);
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
    check("R7", "set and clear together", BUS_W'(frame_err), BUS_W'(1));
    repeat (20) @(negedge clk);
    check("R7", "sticky without clear", BUS_W'(frame_err), BUS_W'(1));
    pulse_clr();
    @(negedge clk);
    check("R7", "clear alone", BUS_W'(frame_err), '0);

    // R9: short reset pulse mid-frame after a good frame and an error
    send_frame(rand_bus(), BUS_W, 1'b1);
    send_frame(rand_bus(), 30, 1'b0);
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; fsync_in = 1'b1;
    @(negedge clk);
    check("R9", "bus after reset pulse", sample_bus, '0);
    check("R9", "valid after reset pulse", BUS_W'(sample_valid), '0);
    check("R9", "err after reset pulse", BUS_W'(frame_err), '0);
    repeat (6) @(negedge clk);
    exp_bus = rand_bus();
    send_frame(exp_bus, BUS_W, 1'b1);
    check("R9", "frame after reset pulse", sample_bus, exp_bus);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule